// File: doc/BRIEF.md
# Status byte and service request unit

This block is the reporting core of an instrument's status structure. It assembles an 8-bit status byte from live summary conditions: the error queue holding entries, the output data queue holding data, a standard event register having any bit set, and an operation summary input. It does not latch these bits. A service request enable register, written and read over a small register bus, selects which status byte bits raise the master summary status. A rising edge of that summary arms a request-for-service flag that drives the service request line.

The status byte is returned on two paths. A query read over the register bus puts the master summary status in bit 6. A serial poll strobe puts the request-for-service flag in bit 6 and clears that flag. The block holds a ten-entry error/status message FIFO, popped by a bus read. It also holds a standard event register that collects event pulses and is cleared when the bus reads it. The questionable summary is tied low because no questionable events exist.

Bus map: address 0 is the status byte query (read only). Address 1 is the enable register (read/write). Address 2 is the event register (read clears it). Address 3 is the error queue head (a read pops it). Bus reads return data combinationally in the strobe cycle. Read side effects take place at the end of that cycle.

Top module: `stat_srq_core`

## Requirements
- R1: After reset the status byte query returns 0x00, the enable register reads 0x00 and `srq` is 0.
- R2: Status bit 7 equals `oper_sum` and bit 4 equals `oq_nonempty` in the same cycle, with no latching. When an input falls, its bit reads 0 again.
- R3: Status bits 3, 1 and 0 always read 0 on both the query and the serial poll paths.
- R4: Error codes pushed with `err_push` are read back at address 3 in first-in first-out order. Status bit 2 is 1 from the cycle after a push while the queue holds entries. It reads 0 once the last entry has been read.
- R5: The error queue holds 10 entries. A push into a full queue with no pop in the same cycle replaces the newest entry with the overflow code `OVF_CODE` (default 0xF0). A read of an empty queue returns 0x00.
- R6: Bits of `ev_set` are ORed into the event register. Status bit 5 is 1 while any event bit is set. A read at address 2 returns the register and clears it. Events set in the same cycle as the read are kept.
- R7: Writes at address 1 store all 8 bits of the enable register, and reads at address 1 return them.
- R8: In a query, bit 6 is 1 exactly when some status bit other than bit 6 is 1 together with its enable bit. Enable bit 6 has no effect.
- R9: A rising edge of the master summary status sets the request-for-service flag at the next clock, and `srq` equals this flag. A serial poll returns the status byte with the flag in bit 6 and clears the flag. The flag stays clear while the summary remains high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the read strobe cycle |
| ev_set | input | 8 | Event pulses into the standard event register |
| err_push | input | 1 | Push a code into the error queue |
| err_code | input | CODE_W | Error code to push |
| oq_nonempty | input | 1 | Output data queue holds data |
| oper_sum | input | 1 | Operation summary condition |
| spoll | input | 1 | Serial poll strobe |
| spoll_data | output | 8 | Status byte with the request flag in bit 6 |
| srq | output | 1 | Service request line |

## Verification
The hardest state to reach is the overflow replacement. The stimulus must fill all ten slots and push once more without popping. Then it drains the queue and checks that only the tenth entry changed to the overflow code, followed by an empty-queue read. The request flag is also delicate. Each rise of the summary re-arms it, so earlier tests can leave it armed. The stimulus therefore polls it clear deliberately, then holds the summary high across a second poll to show that the flag does not re-arm. A read of the event register with a new event in the same cycle checks that clear-on-read does not lose events.

// File: rtl/stat_srq_pkg.sv
package stat_srq_pkg;
   localparam int SB_W    = 8;
   localparam int B_EAV   = 2;
   localparam int B_QSB   = 3;
   localparam int B_MAV   = 4;
   localparam int B_ESB   = 5;
   localparam int B_MSS   = 6;
   localparam int B_OPER  = 7;

   localparam logic [1:0] A_STB = 2'd0;
   localparam logic [1:0] A_SRE = 2'd1;
   localparam logic [1:0] A_EVT = 2'd2;
   localparam logic [1:0] A_ERR = 2'd3;
endpackage

// File: rtl/stat_srq_errq.sv
module stat_srq_errq #(
   parameter int                DEPTH    = 10,
   parameter int                CODE_W   = 8,
   parameter logic [CODE_W-1:0] OVF_CODE = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [CODE_W-1:0] code,
   input  logic              pop,
   output logic [CODE_W-1:0] head,
   output logic              nonempty
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);

   logic [CODE_W-1:0] slot [DEPTH];
   logic [PTR_W-1:0]  wr_ptr, rd_ptr, newest;
   logic [CNT_W-1:0]  count;
   logic              full, do_pop, do_push, replace;

   function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
      return (p == LAST_IDX) ? '0 : p + 1'b1;
   endfunction

   assign full     = (count == CNT_W'(DEPTH));
   assign nonempty = (count != '0);
   assign do_pop   = pop && nonempty;
   assign replace  = push && full && !do_pop;
   assign do_push  = push && !replace;
   assign newest   = (wr_ptr == '0) ? LAST_IDX : wr_ptr - 1'b1;
   assign head     = nonempty ? slot[rd_ptr] : '0;

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk) begin
         if (do_push && wr_ptr == PTR_W'(i))
            slot[i] <= code;
         else if (replace && newest == PTR_W'(i))
            slot[i] <= OVF_CODE;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= bump(wr_ptr);
         if (do_pop)  rd_ptr <= bump(rd_ptr);
         count <= count + CNT_W'(do_push) - CNT_W'(do_pop);
      end
   end
endmodule

// File: rtl/stat_srq_evreg.sv
module stat_srq_evreg #(
   parameter int EV_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [EV_W-1:0] ev_set,
   input  logic            rd_clr,
   output logic [EV_W-1:0] value,
   output logic            summary
);
   always_ff @(posedge clk) begin
      if (!rst_n)      value <= '0;
      else if (rd_clr) value <= ev_set;
      else             value <= value | ev_set;
   end

   assign summary = |value;
endmodule

// File: rtl/stat_srq_req.sv
module stat_srq_req
   import stat_srq_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic [SB_W-1:0] sb_raw,
   input  logic [SB_W-1:0] sre,
   input  logic            poll,
   output logic            mss,
   output logic            rqs
);
   localparam logic [SB_W-1:0] MSS_MASK = ~(SB_W'(1) << B_MSS);

   logic mss_q;

   assign mss = |(sb_raw & sre & MSS_MASK);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mss_q <= 1'b0;
         rqs   <= 1'b0;
      end else begin
         mss_q <= mss;
         if (mss && !mss_q) rqs <= 1'b1;
         else if (poll)     rqs <= 1'b0;
      end
   end
endmodule

// File: rtl/stat_srq_core.sv
module stat_srq_core
   import stat_srq_pkg::*;
#(
   parameter int                ERR_DEPTH = 10,
   parameter int                CODE_W    = 8,
   parameter logic [CODE_W-1:0] OVF_CODE  = 8'hF0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [1:0]        bus_addr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   input  logic [7:0]        ev_set,
   input  logic              err_push,
   input  logic [CODE_W-1:0] err_code,
   input  logic              oq_nonempty,
   input  logic              oper_sum,
   input  logic              spoll,
   output logic [7:0]        spoll_data,
   output logic              srq
);
   if (ERR_DEPTH < 2) begin : g_bad_depth
      $error("ERR_DEPTH must be at least 2");
   end
   if (CODE_W < 1 || CODE_W > SB_W) begin : g_bad_code
      $error("CODE_W must be between 1 and 8");
   end

   logic [SB_W-1:0]   sre, ev_value, sb_raw;
   logic [CODE_W-1:0] err_head;
   logic              eav, esb, mss, rqs;
   logic              rd_stb, rd_evt, rd_err;

   assign rd_stb = bus_rd && bus_addr == A_STB;
   assign rd_evt = bus_rd && bus_addr == A_EVT;
   assign rd_err = bus_rd && bus_addr == A_ERR;

   always_ff @(posedge clk) begin
      if (!rst_n)                           sre <= '0;
      else if (bus_wr && bus_addr == A_SRE) sre <= bus_wdata;
   end

   stat_srq_errq #(
      .DEPTH(ERR_DEPTH), .CODE_W(CODE_W), .OVF_CODE(OVF_CODE)
   ) u_errq (
      .clk(clk), .rst_n(rst_n), .push(err_push), .code(err_code),
      .pop(rd_err), .head(err_head), .nonempty(eav)
   );

   stat_srq_evreg #(.EV_W(SB_W)) u_ev (
      .clk(clk), .rst_n(rst_n), .ev_set(ev_set), .rd_clr(rd_evt),
      .value(ev_value), .summary(esb)
   );

   always_comb begin
      sb_raw         = '0;
      sb_raw[B_EAV]  = eav;
      sb_raw[B_QSB]  = 1'b0;
      sb_raw[B_MAV]  = oq_nonempty;
      sb_raw[B_ESB]  = esb;
      sb_raw[B_OPER] = oper_sum;
   end

   stat_srq_req u_req (
      .clk(clk), .rst_n(rst_n), .sb_raw(sb_raw), .sre(sre),
      .poll(spoll), .mss(mss), .rqs(rqs)
   );

   always_comb begin
      spoll_data        = sb_raw;
      spoll_data[B_MSS] = rqs;
   end
   assign srq = rqs;

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         A_STB: begin
            bus_rdata        = sb_raw;
            bus_rdata[B_MSS] = mss;
         end
         A_SRE:   bus_rdata = sre;
         A_EVT:   bus_rdata = ev_value;
         default: bus_rdata = SB_W'(err_head);
      endcase
   end

   logic unused_rd;
   assign unused_rd = rd_stb;
endmodule

// File: rtl/stat_srq_core_chk.sv
module stat_srq_core_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       bus_rd,
   input logic [1:0] bus_addr,
   input logic [7:0] bus_rdata,
   input logic [7:0] ev_set,
   input logic       err_push,
   input logic       spoll,
   input logic [7:0] spoll_data,
   input logic       srq,
   input logic       mss,
   input logic       esb,
   input logic       eav
);
   p_qsb_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      spoll |-> (spoll_data[3] == 1'b0 && spoll_data[1:0] == 2'b00));

   p_eav_after_push_r4: assert property (@(posedge clk) disable iff (!rst_n)
      err_push |=> eav);

   p_empty_pop_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == 2'd3 && !eav) |-> bus_rdata == 8'h00);

   p_evt_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == 2'd2 && ev_set == 8'h00) |=> !esb);

   p_srq_arm_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mss) |=> srq);

   p_poll_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (spoll && !$rose(mss)) |=> !srq);
endmodule

bind stat_srq_core stat_srq_core_chk u_chk (
   .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_addr(bus_addr),
   .bus_rdata(bus_rdata), .ev_set(ev_set), .err_push(err_push),
   .spoll(spoll), .spoll_data(spoll_data), .srq(srq),
   .mss(mss), .esb(esb), .eav(eav)
);

// File: tb/test_stat_srq_core.sv
`timescale 1ns/1ps
module test_stat_srq_core;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_wr = 1'b0, bus_rd = 1'b0, err_push = 1'b0;
   logic       oq_nonempty = 1'b0, oper_sum = 1'b0, spoll = 1'b0;
   logic [1:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0, ev_set = '0, err_code = '0;
   logic [7:0] bus_rdata, spoll_data;
   logic       srq;

   int n_chk = 0, n_fail = 0;
   logic [7:0] exp_q [$];
   string      tag_q [$];

   always #2 clk = ~clk;

   stat_srq_core i_stat_srq_core (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .ev_set(ev_set), .err_push(err_push), .err_code(err_code),
      .oq_nonempty(oq_nonempty), .oper_sum(oper_sum), .spoll(spoll),
      .spoll_data(spoll_data), .srq(srq)
   );

   task automatic compare(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   // monitor: pops the scoreboard whenever a read or poll is on the pins
   always @(negedge clk) begin
      if (rst_n && (bus_rd || spoll)) begin
         if (exp_q.size() == 0) begin
            n_chk++; n_fail++;
            $display("FAIL scoreboard actual=unexpected-read expected=none");
         end else begin
            compare(tag_q.pop_front(), bus_rd ? bus_rdata : spoll_data, exp_q.pop_front());
         end
      end
   end

   task automatic rd(input logic [1:0] a, input logic [7:0] ev, input logic [7:0] exp, input string tag);
      @(posedge clk); #1;
      exp_q.push_back(exp); tag_q.push_back(tag);
      bus_rd = 1'b1; bus_addr = a; ev_set = ev;
      @(posedge clk); #1;
      bus_rd = 1'b0; ev_set = '0;
   endtask

   task automatic poll(input logic [7:0] exp, input string tag);
      @(posedge clk); #1;
      exp_q.push_back(exp); tag_q.push_back(tag);
      spoll = 1'b1;
      @(posedge clk); #1;
      spoll = 1'b0;
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(posedge clk); #1;
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #1;
      bus_wr = 1'b0;
   endtask

   task automatic push(input logic [7:0] c);
      @(posedge clk); #1;
      err_push = 1'b1; err_code = c;
      @(posedge clk); #1;
      err_push = 1'b0;
   endtask

   task automatic pulse_ev(input logic [7:0] e);
      @(posedge clk); #1;
      ev_set = e;
      @(posedge clk); #1;
      ev_set = '0;
   endtask

   task automatic chk_srq(input logic exp, input string tag);
      @(negedge clk);
      compare(tag, {7'd0, srq}, {7'd0, exp});
   endtask

   task automatic finish_run;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      rd(2'd0, 8'h00, 8'h00, "R1 status byte");
      rd(2'd1, 8'h00, 8'h00, "R1 enable reg");
      chk_srq(1'b0, "R1 srq");

      // R7 enable register round trip
      wr(2'd1, 8'hA5);
      rd(2'd1, 8'h00, 8'hA5, "R7 enable readback");
      wr(2'd1, 8'h00);
      rd(2'd1, 8'h00, 8'h00, "R7 enable cleared");

      // R2 / R3 live summary bits
      oper_sum = 1'b1; oq_nonempty = 1'b1;
      rd(2'd0, 8'h00, 8'h90, "R2 oper and mav set, R3 low bits zero");
      oper_sum = 1'b0;
      rd(2'd0, 8'h00, 8'h10, "R2 oper falls");
      oq_nonempty = 1'b0;
      rd(2'd0, 8'h00, 8'h00, "R2 mav falls");

      // R4 FIFO order and error-available bit
      push(8'h11); push(8'h22); push(8'h33);
      rd(2'd0, 8'h00, 8'h04, "R4 eav set");
      rd(2'd3, 8'h00, 8'h11, "R4 first");
      rd(2'd3, 8'h00, 8'h22, "R4 second");
      rd(2'd3, 8'h00, 8'h33, "R4 third");
      rd(2'd0, 8'h00, 8'h00, "R4 eav cleared");

      // R5 empty pop and overflow replacement
      rd(2'd3, 8'h00, 8'h00, "R5 empty pop");
      for (int i = 1; i <= 10; i++) push(8'(i));
      push(8'h99);
      for (int i = 1; i <= 9; i++) rd(2'd3, 8'h00, 8'(i), "R5 drain kept entry");
      rd(2'd3, 8'h00, 8'hF0, "R5 overflow code in newest slot");
      rd(2'd3, 8'h00, 8'h00, "R5 empty after drain");

      // R6 event register
      pulse_ev(8'h21);
      rd(2'd0, 8'h00, 8'h20, "R6 esb set");
      rd(2'd2, 8'h00, 8'h21, "R6 read value");
      rd(2'd0, 8'h00, 8'h00, "R6 esb cleared after read");
      pulse_ev(8'h01);
      rd(2'd2, 8'h02, 8'h01, "R6 read with new event");
      rd(2'd2, 8'h00, 8'h02, "R6 new event kept");

      // R8 master summary in query
      wr(2'd1, 8'h10);
      oq_nonempty = 1'b1;
      rd(2'd0, 8'h00, 8'h50, "R8 mss with enabled mav");
      wr(2'd1, 8'h40);
      rd(2'd0, 8'h00, 8'h10, "R8 enable bit6 ignored");
      poll(8'h50, "R9 flag armed by earlier rise");
      oq_nonempty = 1'b0;
      chk_srq(1'b0, "R9 srq cleared by poll");

      // R9 request for service
      wr(2'd1, 8'h80);
      chk_srq(1'b0, "R9 srq idle");
      @(posedge clk); #1 oper_sum = 1'b1;
      chk_srq(1'b0, "R9 srq before edge");
      chk_srq(1'b1, "R9 srq after rise");
      poll(8'hC0, "R9 poll returns rqs");
      chk_srq(1'b0, "R9 srq cleared");
      rd(2'd0, 8'h00, 8'hC0, "R8 mss still high in query");
      poll(8'h80, "R9 no re-arm while mss high");
      @(posedge clk); #1 oper_sum = 1'b0;
      @(posedge clk); #1 oper_sum = 1'b1;
      chk_srq(1'b0, "R9 before second rise edge");
      chk_srq(1'b1, "R9 re-armed by new rise");

      repeat (2) @(posedge clk);
      finish_run();
   end
endmodule